// File: doc/BRIEF.md
# Backup Supply Supervisor with Power-On Reset

This block is the digital control core of a battery-backed memory supply. It receives three digitized comparator results each clock: whether the main supply is above its trip point, whether the main supply is above the battery voltage, and whether a battery is attached. From these it decides whether the memory rail is fed from the battery. It drives an active-low system reset, a recovery-done flag for neighbouring blocks, and a shipping-seal status.

Reset follows the trip comparator downward at once. After the supply comes back, reset is held for a stretch of clock cycles. The recovery flag rises earlier in that stretch, so recovery is always complete before reset lets go.

A newly attached battery is held in a sealed state while no main supply is present. In that state it is never switched onto the memory rail. The seal opens on the first clock that sees the main supply above its trip point. Once open, it closes again only when a battery is plugged in while the main supply is absent. All intervals are counted in clock cycles and set by parameters.

Top module: `bkp_supervisor`

## Requirements
- R1: While `rst` is high, and on the first sample after it is released, `sys_rst_n`=0, `recovered`=0, `on_battery`=0 and `sealed`=1.
- R2: `on_battery` is 1 after a clock edge exactly when, at that edge, `supply_ok`=0, `supply_gt_bat`=0, `bat_present`=1 and the seal is open after that edge. Otherwise it is 0.
- R3: A clock edge that sees `supply_ok`=0 drives `sys_rst_n` to 0.
- R4: `sys_rst_n` goes to 1 at the RST_CYCLES-th consecutive edge that sees `supply_ok`=1, and not before.
- R5: `recovered` goes to 1 at the REC_CYCLES-th consecutive edge with `supply_ok`=1, and drops at the first edge with `supply_ok`=0. REC_CYCLES < RST_CYCLES, so `recovered` is 1 whenever `sys_rst_n` is 1.
- R6: An edge that sees `bat_present` go from 0 to 1 while `supply_ok`=0 sets `sealed` to 1. At that same edge `on_battery` is 0.
- R7: The first edge that sees `supply_ok`=1 clears `sealed` to 0.
- R8: A battery attached while `supply_ok`=1 leaves the seal open, and a loss of main supply on its own does not close it.
- R9: A dip of `supply_ok` to 0, even for one edge, restarts the reset and recovery count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Main supply is above its trip point |
| supply_gt_bat | input | 1 | Main supply is above the battery voltage |
| bat_present | input | 1 | A battery is attached |
| on_battery | output | 1 | Memory rail is fed from the battery |
| sys_rst_n | output | 1 | Active-low system reset |
| recovered | output | 1 | Supply has been valid for the recovery interval |
| sealed | output | 1 | Shipping seal is active; battery use is blocked |

## Verification
The bench counts edges exactly at both ends of the reset stretch and the recovery interval. A counter that is off by one releases `sys_rst_n` or `recovered` one sample early or one sample late.

A one-edge dip in the supply is applied near the end of the stretch. A design that pauses the count instead of clearing it releases reset too soon.

A battery is inserted while the supply is low and the seal is open. A switch that reads the old seal state selects the battery for one cycle. The bench also swaps the supply-versus-battery comparison and runs with no battery. These catch a switch rule built on a single condition, and a seal that never opens or never closes.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

    typedef enum logic {
        SEAL_OPEN = 1'b0,
        SEAL_SHUT = 1'b1
    } seal_e;

    typedef struct packed {
        logic supply_ok;
        logic supply_gt_bat;
        logic bat_present;
    } pwr_sense_t;

    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
        return (v >= lim) ? lim : v + 32'd1;
    endfunction

endpackage

// File: rtl/bkp_timer.sv
module bkp_timer #(
    parameter int RST_CYCLES = 20,
    parameter int REC_CYCLES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic sys_rst_n,
    output logic recovered
);
    import bkp_pkg::*;

    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic          rstn_q;
    logic          rec_q;

    always_comb begin
        cnt_nx = CW'(sat_inc(32'(cnt_q), 32'(RST_CYCLES)));
    end

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            cnt_q  <= '0;
            rstn_q <= 1'b0;
            rec_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            rstn_q <= (32'(cnt_nx) >= 32'(RST_CYCLES));
            rec_q  <= (32'(cnt_nx) >= 32'(REC_CYCLES));
        end
    end

    assign sys_rst_n = rstn_q;
    assign recovered = rec_q;

    // R3
    sup_low_rst_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !sys_rst_n);

    // R4
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n) |-> $past(supply_ok));

    initial begin
        if (REC_CYCLES >= RST_CYCLES || REC_CYCLES < 1)
            $display("bkp_timer: REC_CYCLES must be in 1..RST_CYCLES-1");
    end
endmodule

// File: rtl/bkp_seal.sv
module bkp_seal (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic bat_present,
    output logic seal_d,
    output logic sealed
);
    import bkp_pkg::*;

    seal_e state_q;
    seal_e state_d;
    logic  bat_prev_q;

    always_comb begin
        state_d = state_q;
        if (supply_ok)
            state_d = SEAL_OPEN;
        else if (bat_present && !bat_prev_q)
            state_d = SEAL_SHUT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEAL_SHUT;
            bat_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            bat_prev_q <= bat_present;
        end
    end

    assign seal_d = (state_d == SEAL_SHUT);
    assign sealed = (state_q == SEAL_SHUT);

    // R6
    attach_seal_chk: assert property (@(posedge clk) disable iff (rst)
        (bat_present && !bat_prev_q && !supply_ok) |=> sealed);

    // R7
    supply_open_chk: assert property (@(posedge clk) disable iff (rst)
        supply_ok |=> !sealed);
endmodule

// File: rtl/bkp_switch.sv
module bkp_switch (
    input  logic clk,
    input  logic rst,
    input  bkp_pkg::pwr_sense_t sense,
    input  logic seal_d,
    output logic on_battery
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= 1'b0;
        else
            sel_q <= !sense.supply_ok && !sense.supply_gt_bat
                     && sense.bat_present && !seal_d;
    end

    assign on_battery = sel_q;

    // R2
    bat_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        sense.supply_ok |=> !on_battery);
endmodule

// File: rtl/bkp_supervisor.sv
module bkp_supervisor #(
    parameter int RST_CYCLES = 20,
    parameter int REC_CYCLES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic supply_gt_bat,
    input  logic bat_present,
    output logic on_battery,
    output logic sys_rst_n,
    output logic recovered,
    output logic sealed
);
    import bkp_pkg::*;

    pwr_sense_t sense;
    logic       seal_d;

    assign sense = '{supply_ok: supply_ok, supply_gt_bat: supply_gt_bat,
                     bat_present: bat_present};

    bkp_timer #(.RST_CYCLES(RST_CYCLES), .REC_CYCLES(REC_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .supply_ok(supply_ok),
        .sys_rst_n(sys_rst_n), .recovered(recovered)
    );

    bkp_seal u_seal (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .bat_present(bat_present),
        .seal_d(seal_d), .sealed(sealed)
    );

    bkp_switch u_switch (
        .clk(clk), .rst(rst), .sense(sense), .seal_d(seal_d),
        .on_battery(on_battery)
    );

    // R5
    rec_before_rel_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_n |-> recovered);

    // R2
    no_bat_when_sealed_chk: assert property (@(posedge clk) disable iff (rst)
        on_battery |-> !sealed);
endmodule

// File: tb/tb_bkp_supervisor.sv
module tb_bkp_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int RST_C = 20;
    localparam int REC_C = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic supply_gt_bat = 1'b0;
    logic bat_present = 1'b1;
    logic on_battery, sys_rst_n, recovered, sealed;

    int n_chk = 0;
    int n_fail = 0;

    bkp_supervisor #(.RST_CYCLES(RST_C), .REC_CYCLES(REC_C)) dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .supply_gt_bat(supply_gt_bat),
        .bat_present(bat_present), .on_battery(on_battery), .sys_rst_n(sys_rst_n),
        .recovered(recovered), .sealed(sealed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {supply_gt_bat, bat_present, expected on_battery}; supply_ok held low
    localparam logic [2:0] VEC [0:4] = '{3'b011, 3'b110, 3'b011, 3'b100, 3'b000};

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 rst_n", sys_rst_n, 1'b0);
        chk("R1 recovered", recovered, 1'b0);
        chk("R1 on_battery", on_battery, 1'b0);
        chk("R1 sealed", sealed, 1'b1);
        rst = 1'b0;
        step(1);
        chk("R1 sealed after release", sealed, 1'b1);
        step(1);
        // R6 sealed battery is not used although supply is low
        chk("R6 sealed blocks battery", on_battery, 1'b0);

        // R7, R4, R5 power-up
        supply_ok = 1'b1; supply_gt_bat = 1'b1;
        step(1);
        chk("R7 seal opens", sealed, 1'b0);
        chk("R4 held in reset", sys_rst_n, 1'b0);
        step(REC_C - 2);
        chk("R5 not yet recovered", recovered, 1'b0);
        step(1);
        chk("R5 recovered", recovered, 1'b1);
        chk("R4 still in reset", sys_rst_n, 1'b0);
        step(RST_C - REC_C - 1);
        chk("R4 reset at RST-1", sys_rst_n, 1'b0);
        step(1);
        chk("R4 reset released", sys_rst_n, 1'b1);

        // R2 table with supply low
        supply_ok = 1'b0;
        foreach (VEC[i]) begin
            supply_gt_bat = VEC[i][2];
            bat_present   = VEC[i][1];
            step(1);
            chk("R2 switch", on_battery, VEC[i][0]);
            chk("R3 reset low", sys_rst_n, 1'b0);
            chk("R5 recovered low", recovered, 1'b0);
        end

        // R9 glitch restarts stretch
        supply_ok = 1'b1; supply_gt_bat = 1'b1; bat_present = 1'b0;
        step(RST_C - 1);
        supply_ok = 1'b0;
        step(1);
        chk("R9 dip resets", sys_rst_n, 1'b0);
        supply_ok = 1'b1;
        step(RST_C - 1);
        chk("R9 restart count", sys_rst_n, 1'b0);
        step(1);
        chk("R9 release after full count", sys_rst_n, 1'b1);

        // R8 attach while supply high, then lose supply
        bat_present = 1'b1;
        step(1);
        chk("R8 attach with supply", sealed, 1'b0);
        supply_ok = 1'b0; supply_gt_bat = 1'b0;
        step(1);
        chk("R8 supply loss keeps seal open", sealed, 1'b0);
        chk("R8 battery selected", on_battery, 1'b1);

        // R6 attach while supply low
        bat_present = 1'b0;
        step(1);
        chk("R2 no battery", on_battery, 1'b0);
        bat_present = 1'b1;
        step(1);
        chk("R6 seal on attach", sealed, 1'b1);
        chk("R6 no battery at attach edge", on_battery, 1'b0);
        step(2);
        chk("R6 stays sealed", on_battery, 1'b0);

        // R7 reopen
        supply_ok = 1'b1;
        step(1);
        chk("R7 reopen", sealed, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule